// File: doc/BRIEF.md
# Word-Parallel 33-Bit Pseudo-Random Generator

This block produces pseudo-random 32-bit words from a 33-bit feedback state. The state is a 32-bit low word and one extra high bit. A single clock computes a complete 32-bit update, so every enabled cycle delivers a fresh word, with no run of single-bit shifts in between. The update first rotates the 33-bit state right by one place. It then folds the result through two shift-and-XOR stages.

A consumer raises the step input on each cycle in which it wants a new value. Both outputs come straight from the state registers, so they hold steady between steps. A seed port writes all 33 state bits at once and takes priority over stepping. A synchronous reset restores a fixed nonzero default.

From any nonzero state the sequence runs through 2^33 - 1 states before it repeats. The all-zero state is a trap: the block stays at zero once it holds it.

Top module: `rng33_word_gen`

## Requirements
- R1: On a clock edge with `rst` high, the low word becomes 0x55555555 and the high bit becomes 1.
- R2: On an edge with `step_en` high and `seed_load` low, the new low word is u XOR (u >> 20), where u = {H, L[31:1]} XOR (L << 12) truncated to 32 bits, both shifts logical. From the reset state the first three steps give 0xFFFFF555, 0x00AAAAA0 and 0x2AFF57FF.
- R3: On a step, the new high bit equals bit 0 of the old low word. From reset the first three steps give high bits 1, 1 and 0.
- R4: On an edge with both `step_en` and `seed_load` low, neither output changes.
- R5: On an edge with `seed_load` high, the state takes `seed_val`, regardless of `step_en`. `seed_val[32]` becomes the high bit and `seed_val[31:0]` becomes the low word.
- R6: Once the state is all zero, stepping keeps both outputs at zero.
- R7: Stepping from a nonzero state never yields the all-zero state.
- R8: `rnd_word` and `rnd_hi` are registers. They show the state reached after the most recent edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | Advance the state by one word on this edge |
| seed_load | input | 1 | Write `seed_val` into the state; takes priority over `step_en` |
| seed_val | input | 33 | Seed: bit 32 is the high bit, bits 31:0 are the low word |
| rnd_word | output | 32 | Current low word, used as the random value |
| rnd_hi | output | 1 | Current high state bit |

## Verification
The bench builds the block with its default parameters: a 32-bit word, a left fold of 12 and a right fold of 20, which is the only combination that gives the full-period sequence. With these values the first steps after reset can be worked out by hand and compared exactly. A bench model of the update then tracks several thousand steps, which reaches high-bit values of both polarities and low words with both folds active. Seeding with zero puts the block in the lock-up state, which the reset default never reaches.

// File: rtl/rng33_pkg.sv
package rng33_pkg;
  localparam int WORD_W = 32;
  localparam int ST_W   = WORD_W + 1;

  typedef struct packed {
    logic              hi;
    logic [WORD_W-1:0] lo;
  } rng_state_t;
endpackage

// File: rtl/rng33_rotate.sv
module rng33_rotate
  import rng33_pkg::*;
(
  input  rng_state_t        cur,
  output logic [WORD_W-1:0] rot,
  output logic              hi_next
);
  // one-place right rotation through the extra state bit
  always_comb begin
    rot     = {cur.hi, cur.lo[WORD_W-1:1]};
    hi_next = cur.lo[0];
  end
endmodule

// File: rtl/rng33_mix.sv
module rng33_mix
  import rng33_pkg::*;
#(
  parameter int SHL = 12,
  parameter int SHR = 20
) (
  input  logic [WORD_W-1:0] cur_lo,
  input  logic [WORD_W-1:0] rot,
  output logic [WORD_W-1:0] nxt_lo
);
  logic [WORD_W-1:0] fold_a;

  always_comb begin
    fold_a = rot ^ (cur_lo << SHL);
    nxt_lo = fold_a ^ (fold_a >> SHR);
  end
endmodule

// File: rtl/rng33_state.sv
module rng33_state
  import rng33_pkg::*;
#(
  parameter logic [WORD_W-1:0] RESET_LO = 32'h5555_5555,
  parameter logic              RESET_HI = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       step_en,
  input  logic       seed_load,
  input  rng_state_t seed,
  input  rng_state_t nxt,
  output rng_state_t q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q.lo <= RESET_LO;
      q.hi <= RESET_HI;
    end else if (seed_load) begin
      q <= seed;
    end else if (step_en) begin
      q <= nxt;
    end
  end

  AST_RESET_VALUE: assert property (@(posedge clk) rst |=> (q.lo == RESET_LO && q.hi == RESET_HI)); // R1
  AST_HI_FROM_LSB: assert property (@(posedge clk) disable iff (rst)
    (step_en && !seed_load) |=> q.hi == $past(q.lo[0])); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!step_en && !seed_load) |=> $stable(q)); // R4
  AST_SEED_WINS: assert property (@(posedge clk) disable iff (rst)
    seed_load |=> q == $past(seed)); // R5
  AST_ZERO_TRAP: assert property (@(posedge clk) disable iff (rst)
    (q == '0 && !seed_load) |=> q == '0); // R6
  AST_NO_DEAD_STEP: assert property (@(posedge clk) disable iff (rst)
    (q != '0 && !seed_load) |=> q != '0); // R7
endmodule

// File: rtl/rng33_word_gen.sv
module rng33_word_gen
  import rng33_pkg::*;
#(
  parameter int                SHL      = 12,
  parameter int                SHR      = 20,
  parameter logic [WORD_W-1:0] RESET_LO = 32'h5555_5555,
  parameter logic              RESET_HI = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_en,
  input  logic              seed_load,
  input  logic [ST_W-1:0]   seed_val,
  output logic [WORD_W-1:0] rnd_word,
  output logic              rnd_hi
);
  rng_state_t        cur_q;
  rng_state_t        nxt_d;
  rng_state_t        seed_s;
  logic [WORD_W-1:0] rot_w;
  logic              hi_w;
  logic [WORD_W-1:0] lo_w;

  assign seed_s = rng_state_t'(seed_val);

  rng33_rotate u_rotate (
    .cur     (cur_q),
    .rot     (rot_w),
    .hi_next (hi_w)
  );

  rng33_mix #(.SHL(SHL), .SHR(SHR)) u_mix (
    .cur_lo (cur_q.lo),
    .rot    (rot_w),
    .nxt_lo (lo_w)
  );

  assign nxt_d.hi = hi_w;
  assign nxt_d.lo = lo_w;

  rng33_state #(.RESET_LO(RESET_LO), .RESET_HI(RESET_HI)) u_state (
    .clk       (clk),
    .rst       (rst),
    .step_en   (step_en),
    .seed_load (seed_load),
    .seed      (seed_s),
    .nxt       (nxt_d),
    .q         (cur_q)
  );

  // R8: outputs are taken straight from the state registers
  assign rnd_word = cur_q.lo;
  assign rnd_hi   = cur_q.hi;

  AST_OUT_STEADY: assert property (@(posedge clk) disable iff (rst)
    (!step_en && !seed_load) |=> ($stable(rnd_word) && $stable(rnd_hi))); // R8
endmodule

// File: tb/test_rng33_word_gen.sv
module test_rng33_word_gen;
  logic        clk = 1'b0;
  logic        rst;
  logic        step_en;
  logic        seed_load;
  logic [32:0] seed_val;
  logic [31:0] rnd_word;
  logic        rnd_hi;

  int n_checks = 0;
  int n_fails  = 0;

  always #2 clk = ~clk;

  rng33_word_gen i_rng33_word_gen (
    .clk       (clk),
    .rst       (rst),
    .step_en   (step_en),
    .seed_load (seed_load),
    .seed_val  (seed_val),
    .rnd_word  (rnd_word),
    .rnd_hi    (rnd_hi)
  );

  // expected {hi, word} after steps 1..3 from the reset state (R2, R3)
  localparam logic [32:0] STEP_TABLE [3] = '{33'h1_FFFF_F555, 33'h1_00AA_AAA0, 33'h0_2AFF_57FF};

  function automatic logic [32:0] model_step(input logic [32:0] s);
    logic [31:0] u;
    u = {s[32], s[31:1]} ^ (s[31:0] << 12);
    return {s[0], u ^ (u >> 20)};
  endfunction

  task automatic chk(input string req, input logic [32:0] act, input logic [32:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(4 * 100000);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    logic [32:0] ref_s;
    rst = 1'b1; step_en = 1'b0; seed_load = 1'b0; seed_val = '0;
    tick(); tick();
    rst = 1'b0;
    chk("R1 reset state", {rnd_hi, rnd_word}, 33'h1_5555_5555);

    // table walk: first steps after reset (R2, R3, R8)
    step_en = 1'b1;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R2/R3 table step", {rnd_hi, rnd_word}, STEP_TABLE[i]);
    end

    // hold (R4)
    step_en = 1'b0;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R4 hold", {rnd_hi, rnd_word}, STEP_TABLE[2]);
    end

    // long run against the model (R2, R3, R7)
    ref_s = STEP_TABLE[2];
    step_en = 1'b1;
    for (int i = 0; i < 5000; i++) begin
      tick();
      ref_s = model_step(ref_s);
      chk("R2 word", {1'b0, rnd_word}, {1'b0, ref_s[31:0]});
      chk("R3 hi", {32'd0, rnd_hi}, {32'd0, ref_s[32]});
      chk("R7 nonzero", {32'd0, ({rnd_hi, rnd_word} != 33'd0)}, 33'd1);
    end

    // seed load overrides step (R5)
    seed_load = 1'b1; seed_val = 33'h1_2345_6789;
    tick();
    chk("R5 seed load", {rnd_hi, rnd_word}, 33'h1_2345_6789);
    seed_load = 1'b0;
    tick();
    chk("R2 step from seed", {rnd_hi, rnd_word}, model_step(33'h1_2345_6789));

    // zero trap (R6)
    seed_load = 1'b1; seed_val = '0;
    tick();
    seed_load = 1'b0;
    chk("R5 zero seed", {rnd_hi, rnd_word}, 33'd0);
    for (int i = 0; i < 100; i++) begin
      tick();
      chk("R6 zero trap", {rnd_hi, rnd_word}, 33'd0);
    end

    // reset mid-run leaves zero trap (R1)
    rst = 1'b1;
    tick();
    rst = 1'b0;
    chk("R1 reset from zero", {rnd_hi, rnd_word}, 33'h1_5555_5555);
    tick();
    chk("R2 first step after reset", {rnd_hi, rnd_word}, STEP_TABLE[0]);
    step_en = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule